// File: doc/BRIEF.md
# L1 Link Power Sequencer

This block sits in a bridge that drives a PCI Express link downstream. It decides when that link may go into the L1 low-power state and when it must come back. It follows the power D-state of the downstream function and four link states: L0, entry pending, L1 and exit. When the function has been put in D3hot, an L1 entry message from the device is answered with an acknowledge request to the transmitter. This answer is given at once, even when a configuration request is waiting. The device is not allowed to complete that request until it has been acknowledged, so waiting for the completion first would deadlock the link.

Configuration requests to the downstream device go out only through a grant, and the grant is given only while the link is fully in L0. A request raised outside L0 stays pending at the requester. If the link is in L1, the request makes the block start the exit toward L0. The request is granted once link training reports that the link is up again, so nothing is transmitted while the link is still waking. An exit that takes longer than a programmable number of cycles sets a sticky error flag.

Top module: `l1_link_seq`

## Requirements
- R1: After reset the link state is L0 (code 0), tx_allowed is 1, and tx_pm_ack, exit_req, cfg_grant and exit_err are 0.
- R2: link_state reports L0=0, entry pending=1, L1=2, exit=3. tx_allowed is 1 exactly when link_state is 0.
- R3: In L0, an rx_enter_l1 strobe taken while dstate_d3hot is 1 moves the state to entry pending at the next edge. With dstate_d3hot at 0 the strobe is ignored: the state stays L0 and no acknowledge follows.
- R4: tx_pm_ack is a one-cycle pulse, high in the cycle after each accepted entry message. An accepted message is one that moves L0 to entry pending, or any rx_enter_l1 strobe seen in entry pending.
- R5: The acknowledge in R4 does not depend on cfg_req. It is issued the same way while a configuration request is pending.
- R6: cfg_grant equals cfg_req while the state is L0 and is 0 in every other state.
- R7: Entry pending moves to L1 at the edge where link_up is 0, and stays in entry pending while link_up is 1.
- R8: L1 moves to exit at the next edge when cfg_req is 1 or dstate_d3hot is 0. exit_req is 1 exactly while the state is exit.
- R9: Exit moves to L0 at the edge where link_up is 1. A configuration request held high through entry, L1 and exit is granted in the first L0 cycle after that.
- R10: If the state stays in exit with link_up at 0, exit_err rises exit_limit+1 cycles after the exit began. Once set, exit_err stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dstate_d3hot | input | 1 | Downstream function is in D3hot |
| rx_enter_l1 | input | 1 | Strobe: an L1 entry request message was received |
| cfg_req | input | 1 | Configuration request pending, held until granted |
| link_up | input | 1 | Link training reports the link active in L0 |
| exit_limit | input | CNT_W | Cycles allowed for an L1 exit before the error flag |
| tx_pm_ack | output | 1 | Pulse: transmit the PM acknowledge message |
| cfg_grant | output | 1 | The pending configuration request may be forwarded now |
| tx_allowed | output | 1 | Link is fully in L0 and TLPs may be transmitted |
| exit_req | output | 1 | Ask the physical layer to bring the link back to L0 |
| link_state | output | 2 | Current link power state code |
| exit_err | output | 1 | Sticky: an L1 exit exceeded exit_limit |

## Verification
The assertions assume that cfg_req, once raised, stays high until a grant is seen. They assume that link_up falls only after an acknowledge has been sent, and rises again only while an exit is under way. They also assume that exit_limit stays constant while an exit is in progress. The bench drives a requester that holds its request, and it changes link_up only at those points in the sequence. It sets exit_limit once, before any exit starts. A behavioural model is stepped on every clock and compared with all the outputs.

// File: rtl/l1seq_pkg.sv
package l1seq_pkg;
    typedef enum logic [1:0] {
        LS_L0    = 2'd0,
        LS_ENTRY = 2'd1,
        LS_L1    = 2'd2,
        LS_EXIT  = 2'd3
    } lstate_t;

    typedef struct packed {
        lstate_t st;
    } seq_t;

    typedef struct packed {
        logic ack;
    } ack_t;
endpackage

// File: rtl/l1seq_ack_gen.sv
module l1seq_ack_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse
);
    import l1seq_pkg::*;

    ack_t a_d, a_q;

    always_comb begin
        a_d.ack = fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign pulse = a_q.ack;
endmodule

// File: rtl/l1seq_exit_timer.sv
module l1seq_exit_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             link_up,
    input  logic [CNT_W-1:0] limit,
    output logic             err
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             err;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (!run) begin
            t_d.cnt = '0;
        end else if (!link_up) begin
            if (t_q.cnt == limit) t_d.err = 1'b1;
            else                  t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign err = t_q.err;
endmodule

// File: rtl/l1_link_seq.sv
module l1_link_seq #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dstate_d3hot,
    input  logic             rx_enter_l1,
    input  logic             cfg_req,
    input  logic             link_up,
    input  logic [CNT_W-1:0] exit_limit,
    output logic             tx_pm_ack,
    output logic             cfg_grant,
    output logic             tx_allowed,
    output logic             exit_req,
    output logic [1:0]       link_state,
    output logic             exit_err
);
    import l1seq_pkg::*;

    seq_t s_d, s_q;
    logic ack_fire;

    // next state; the acknowledge never waits on cfg_req
    always_comb begin
        s_d      = s_q;
        ack_fire = 1'b0;
        unique case (s_q.st)
            LS_L0: begin
                if (rx_enter_l1 && dstate_d3hot) begin
                    s_d.st   = LS_ENTRY;
                    ack_fire = 1'b1;
                end
            end
            LS_ENTRY: begin
                ack_fire = rx_enter_l1;
                if (!link_up) s_d.st = LS_L1;
            end
            LS_L1: begin
                if (cfg_req || !dstate_d3hot) s_d.st = LS_EXIT;
            end
            LS_EXIT: begin
                if (link_up) s_d.st = LS_L0;
            end
            default: s_d.st = LS_L0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: LS_L0};
        else        s_q <= s_d;
    end

    l1seq_ack_gen u_ack (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (ack_fire),
        .pulse (tx_pm_ack)
    );

    l1seq_exit_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (s_q.st == LS_EXIT),
        .link_up (link_up),
        .limit   (exit_limit),
        .err     (exit_err)
    );

    assign tx_allowed = (s_q.st == LS_L0);
    assign cfg_grant  = cfg_req && tx_allowed;
    assign exit_req   = (s_q.st == LS_EXIT);
    assign link_state = s_q.st;
endmodule

// File: rtl/l1_link_seq_chk.sv
module l1_link_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dstate_d3hot,
    input logic       rx_enter_l1,
    input logic       cfg_req,
    input logic       link_up,
    input logic       tx_pm_ack,
    input logic       cfg_grant,
    input logic [1:0] link_state,
    input logic       exit_err
);
    a_r3_enter_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == 2'd0 && rx_enter_l1 && dstate_d3hot) |=> (link_state == 2'd1));

    a_r4_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == 2'd0 && rx_enter_l1 && dstate_d3hot) |=> tx_pm_ack);

    a_r5_ack_not_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == 2'd1 && rx_enter_l1 && cfg_req) |=> tx_pm_ack);

    a_r6_grant_in_l0: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_grant |-> (link_state == 2'd0));

    a_r8_wake_on_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == 2'd2 && cfg_req) |=> (link_state == 2'd3));

    a_r9_exit_done: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == 2'd3 && link_up) |=> (link_state == 2'd0));

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        exit_err |=> exit_err);
endmodule

bind l1_link_seq l1_link_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dstate_d3hot (dstate_d3hot),
    .rx_enter_l1  (rx_enter_l1),
    .cfg_req      (cfg_req),
    .link_up      (link_up),
    .tx_pm_ack    (tx_pm_ack),
    .cfg_grant    (cfg_grant),
    .link_state   (link_state),
    .exit_err     (exit_err)
);

// File: tb/l1_link_seq_bench.sv
`timescale 1ns/1ps
module l1_link_seq_bench;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic d3 = 1'b0, rx = 1'b0, cfg = 1'b0, lup = 1'b1;
    logic [CNT_W-1:0] lim = 16'd5;
    logic tx_pm_ack, cfg_grant, tx_allowed, exit_req, exit_err;
    logic [1:0] link_state;

    int total = 0;
    int bad = 0;
    int m_st = 0;
    int m_cnt = 0;
    bit m_ack = 0;
    bit m_err = 0;

    always #4 clk = ~clk;

    l1_link_seq #(.CNT_W(CNT_W)) u_l1_link_seq (
        .clk(clk), .rst_n(rst_n), .dstate_d3hot(d3), .rx_enter_l1(rx),
        .cfg_req(cfg), .link_up(lup), .exit_limit(lim),
        .tx_pm_ack(tx_pm_ack), .cfg_grant(cfg_grant), .tx_allowed(tx_allowed),
        .exit_req(exit_req), .link_state(link_state), .exit_err(exit_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check(int'(link_state) == m_st, "R2 link_state", int'(link_state), m_st);
        check(tx_allowed == (m_st == 0), "R2 tx_allowed", int'(tx_allowed), int'(m_st == 0));
        check(tx_pm_ack == m_ack, "R4 tx_pm_ack", int'(tx_pm_ack), int'(m_ack));
        check(cfg_grant == (cfg && m_st == 0), "R6 cfg_grant", int'(cfg_grant), int'(cfg && m_st == 0));
        check(exit_req == (m_st == 3), "R8 exit_req", int'(exit_req), int'(m_st == 3));
        check(exit_err == m_err, "R10 exit_err", int'(exit_err), int'(m_err));
    endtask

    // one clock: model advances with the inputs held across the edge
    task automatic tick();
        int  n_st = m_st;
        int  n_cnt = m_cnt;
        bit  n_err = m_err;
        bit  n_ack = 0;
        case (m_st)
            0: if (rx && d3) begin n_st = 1; n_ack = 1; end
            1: begin n_ack = rx; if (!lup) n_st = 2; end
            2: if (cfg || !d3) n_st = 3;
            default: if (lup) n_st = 0;
        endcase
        if (m_st != 3) n_cnt = 0;
        else if (!lup) begin
            if (m_cnt == int'(lim)) n_err = 1;
            else n_cnt = m_cnt + 1;
        end
        @(posedge clk);
        m_st = n_st; m_cnt = n_cnt; m_err = n_err; m_ack = n_ack;
        #2;
        compare_all();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #200000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset values
        check(link_state == 2'd0 && tx_allowed && !tx_pm_ack && !exit_req && !cfg_grant && !exit_err,
              "R1 reset", int'(link_state), 0);
        rst_n = 1'b1;
        ticks(2);

        // R3: entry message without D3hot is ignored
        rx = 1; tick(); rx = 0; tick();
        check(link_state == 2'd0 && !tx_pm_ack, "R3 ignored without d3hot", int'(link_state), 0);

        // R6: grant in L0
        cfg = 1; #1;
        check(cfg_grant == 1'b1, "R6 grant in L0", int'(cfg_grant), 1);
        tick(); cfg = 0; tick();

        // R3/R4: accepted entry
        d3 = 1; rx = 1; tick(); rx = 0;
        check(link_state == 2'd1 && tx_pm_ack, "R3 R4 entry and ack", int'(link_state), 1);
        tick();
        check(!tx_pm_ack, "R4 single pulse", int'(tx_pm_ack), 0);

        // R5: request pending, repeated entry message still acked
        cfg = 1; tick();
        rx = 1; tick(); rx = 0;
        check(tx_pm_ack && !cfg_grant, "R5 ack with cfg pending", int'(tx_pm_ack), 1);
        ticks(2);
        check(link_state == 2'd1, "R7 stays while link_up", int'(link_state), 1);

        // R7: link drops
        lup = 0; tick();
        check(link_state == 2'd2, "R7 enter L1", int'(link_state), 2);

        // R8: held request starts exit
        tick();
        check(link_state == 2'd3 && exit_req && !cfg_grant, "R8 exit on cfg", int'(link_state), 3);
        ticks(2);
        lup = 1; tick();
        check(link_state == 2'd0 && cfg_grant, "R9 replay after exit", int'(cfg_grant), 1);
        cfg = 0; tick();

        // second cycle: exit on D3hot release, with timeout
        rx = 1; tick(); rx = 0;
        lup = 0; tick();
        check(link_state == 2'd2, "R7 enter L1 again", int'(link_state), 2);
        ticks(3);
        check(link_state == 2'd2 && !exit_req, "R8 stays in L1", int'(link_state), 2);
        d3 = 0; tick();
        check(exit_req == 1'b1, "R8 exit on d3hot release", int'(exit_req), 1);
        ticks(5);
        check(!exit_err, "R10 no error before limit", int'(exit_err), 0);
        tick();
        check(exit_err == 1'b1, "R10 error after limit+1", int'(exit_err), 1);
        lup = 1; tick();
        check(link_state == 2'd0, "R9 back to L0", int'(link_state), 0);
        ticks(3);
        check(exit_err == 1'b1, "R10 error sticky", int'(exit_err), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule